// File: doc/BRIEF.md
# Two-Output Switch Controller on an SMBus Write

This block is a bus slave for a two-wire serial bus with open-drain clock and data lines. It samples both lines with a fast system clock and cleans them with a synchronizer and a short majority-free glitch filter. It then finds Start and Stop conditions and decodes a single write transaction that carries one command byte. The two low bits of that byte set two enable outputs, which drive external high-side switches.

The slave address is a fixed base plus an offset chosen by two three-level strap inputs. This gives nine neighbouring addresses, so nine devices can share one bus. The command byte is held in a pending register once it has been acknowledged. It reaches the outputs only when the master closes the transaction with a Stop. An interrupted transaction therefore never leaves the switches in an intermediate state.

The data line is never driven high. The block only pulls it low, through `sda_oe`, to acknowledge.

Top module: `smbg_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `gate_a`, `gate_b` and `sda_oe` are 0. Any pending command is dropped.
- R2: At a Stop after an acknowledged command byte, `gate_a` takes bit 0 of that byte and `gate_b` takes bit 1.
- R3: Neither gate output changes when the command byte is acknowledged. Outputs change only in response to a Stop.
- R4: The slave address is 0x48 + 3*level(`strap_hi`) + level(`strap_lo`). For each strap, code 00 is level 0 (low), 01 is level 1 (mid) and 10 is level 2 (high). Code 11 is also taken as level 2. An address byte (address in bits 7..1, R/W in bit 0, sent MSB first) with any other address is not acknowledged, and the outputs keep their values.
- R5: `sda_oe` is 1 during the ninth clock of an accepted address byte and of the command byte. It is 0 again once the falling edge that ends that clock has passed the input filter.
- R6: A matching address with R/W = 1 is not acknowledged, and the outputs keep their values.
- R7: A repeated Start before the Stop discards the pending command. A later Stop then leaves the outputs unchanged.
- R8: A Stop that follows an accepted address but no complete command byte leaves the outputs unchanged.
- R9: Bytes after the command byte are not acknowledged and do not alter the command that the Stop applies.
- R10: A data-line pulse shorter than three system clocks, while the clock line is high, is not taken as a Start or a Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| strap_hi | input | 2 | Pre-decoded level of the upper address strap |
| strap_lo | input | 2 | Pre-decoded level of the lower address strap |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| gate_a | output | 1 | Enable for switch A |
| gate_b | output | 1 | Enable for switch B |

## Verification
A line change at the pins reaches the bus decoder after two synchronizer flops, three filter samples and one edge register, about seven system clocks. A Stop therefore updates the gate outputs roughly eight clocks after the data line rises. The acknowledge drive appears about seven clocks after the falling bus clock edge. The bench holds every bus phase for 25 system clocks. It samples the acknowledge in the middle of the high phase of the ninth clock, checks that the outputs are unchanged before the Stop, and reads the gates 50 clocks after the Stop. A too-short filter or a missing commit therefore shows up at the port and does not depend on a single edge.

// File: rtl/smbg_pkg.sv
package smbg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_CMD,
    ST_ACK_CMD,
    ST_SKIP
  } eng_state_e;

  // Three-level strap code to numeric level; code 11 folds onto high.
  function automatic logic [1:0] strap_level(input logic [1:0] code);
    return (code == 2'b11) ? 2'd2 : code;
  endfunction

  function automatic logic [6:0] strap_addr(input logic [6:0] base,
                                            input logic [1:0] hi_code,
                                            input logic [1:0] lo_code);
    logic [6:0] hi_lvl;
    logic [6:0] lo_lvl;
    hi_lvl = {5'd0, strap_level(hi_code)};
    lo_lvl = {5'd0, strap_level(lo_code)};
    return base + (hi_lvl * 7'd3) + lo_lvl;
  endfunction

endpackage

// File: rtl/smbg_line_filter.sv
module smbg_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        filt <= 1'b1;
      else if (~|hist_q)
        filt <= 1'b0;
    end
  end

  // R10: a filtered change is never followed by an immediate reversal
  p_filt_settle_r10: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |=> $stable(filt));

endmodule

// File: rtl/smbg_bus_cond.sv
module smbg_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_comb begin
    scl_rise  = scl & ~scl_d;
    scl_fall  = ~scl & scl_d;
    start_evt = scl & scl_d & sda_d & ~sda;
    stop_evt  = scl & scl_d & ~sda_d & sda;
  end

endmodule

// File: rtl/smbg_engine.sv
module smbg_engine
  import smbg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int GATES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              sda_oe,
  output logic [GATES-1:0]  gates
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  eng_state_e        st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [GATES-1:0]  pend;
  logic              pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      pend     <= '0;
      pend_vld <= 1'b0;
      gates    <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_evt) begin
      if (pend_vld) gates <= pend;
      pend_vld <= 1'b0;
      sda_oe   <= 1'b0;
      st       <= ST_IDLE;
    end else if (start_evt) begin
      pend_vld <= 1'b0;
      sda_oe   <= 1'b0;
      bit_cnt  <= '0;
      st       <= ST_ADDR;
    end else begin
      case (st)
        ST_ADDR, ST_CMD: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == LAST_BIT) begin
            if (st == ST_CMD) begin
              pend     <= shreg[GATES-1:0];
              pend_vld <= 1'b1;
              sda_oe   <= 1'b1;
              st       <= ST_ACK_CMD;
            end else if (shreg[BYTE_W-1:1] == my_addr && !shreg[0]) begin
              sda_oe <= 1'b1;
              st     <= ST_ACK_ADDR;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        ST_ACK_ADDR: if (scl_fall) begin
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
          st      <= ST_CMD;
        end
        ST_ACK_CMD: if (scl_fall) begin
          sda_oe <= 1'b0;
          st     <= ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  // R3: outputs move only in response to a Stop
  p_gate_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !stop_evt |=> $stable(gates));

  // R7: a (repeated) Start always invalidates the pending command
  p_start_drop_r7: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !pend_vld);

  // R5: pull-down only inside an acknowledge slot
  p_oe_slot_r5: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st == ST_ACK_ADDR || st == ST_ACK_CMD));

  // R5: the acknowledge clock's falling edge releases the line
  p_oe_release_r5: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && scl_fall) |=> !sda_oe);

endmodule

// File: rtl/smbg_top.sv
module smbg_top
  import smbg_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h48,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] strap_hi,
  input  logic [1:0] strap_lo,
  output logic       sda_oe,
  output logic       gate_a,
  output logic       gate_b
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] clean_lines;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic [6:0]        my_addr;
  logic [1:0]        gates;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    smbg_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) i_filt (
      .clk (clk),
      .rst (rst),
      .raw (raw_lines[g]),
      .filt(clean_lines[g])
    );
  end

  smbg_bus_cond i_cond (
    .clk      (clk),
    .rst      (rst),
    .scl      (clean_lines[0]),
    .sda      (clean_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  assign my_addr = strap_addr(BASE_ADDR, strap_hi, strap_lo);

  smbg_engine #(
    .ADDR_W(7),
    .GATES (2)
  ) i_eng (
    .clk      (clk),
    .rst      (rst),
    .sda      (clean_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .my_addr  (my_addr),
    .sda_oe   (sda_oe),
    .gates    (gates)
  );

  assign gate_a = gates[0];
  assign gate_b = gates[1];

  // R1: quiet outputs in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!gate_a && !gate_b && !sda_oe));

endmodule

// File: tb/test_smbg_top.sv
module test_smbg_top;

  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap_hi = 2'b00;
  logic [1:0] strap_lo = 2'b00;
  logic       sda_line;
  logic       sda_oe, gate_a, gate_b;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  smbg_top i_smbg_top (
    .clk     (clk),
    .rst     (rst),
    .scl_in  (scl_m),
    .sda_in  (sda_line),
    .strap_hi(strap_hi),
    .strap_lo(strap_lo),
    .sda_oe  (sda_oe),
    .gate_a  (gate_a),
    .gate_b  (gate_b)
  );

  // {hi[22:21], lo[20:19], addr byte[18:11], cmd[10:3], ack[2], gates {b,a}[1:0]}
  localparam logic [22:0] VEC [8] = '{
    {2'b00, 2'b00, 8'h90, 8'h01, 1'b1, 2'b01},
    {2'b00, 2'b01, 8'h92, 8'h02, 1'b1, 2'b10},
    {2'b01, 2'b10, 8'h9A, 8'h03, 1'b1, 2'b11},
    {2'b10, 2'b10, 8'hA0, 8'hFC, 1'b1, 2'b00},
    {2'b10, 2'b00, 8'h9E, 8'h03, 1'b0, 2'b00},
    {2'b01, 2'b01, 8'h99, 8'h03, 1'b0, 2'b00},
    {2'b11, 2'b11, 8'hA0, 8'h01, 1'b1, 2'b01},
    {2'b10, 2'b01, 8'h9E, 8'hFE, 1'b1, 2'b10}
  };

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wc(2*Q);
    scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wc(Q);
    scl_m = 1'b1; wc(Q);
    sda_m = 1'b0; wc(Q);
    scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wc(Q);
    scl_m = 1'b1; wc(Q);
    sda_m = 1'b1; wc(2*Q);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; wc(Q);
    scl_m = 1'b1; wc(Q);
    s = sda_line; wc(Q);
    scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
    chk("R5 line released after ack clock", {7'd0, sda_oe}, 8'd0);
  endtask

  logic [1:0] exp_g = 2'b00;
  logic       ack;

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 run hung actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wc(10);
    chk("R1 gates during reset", {6'd0, gate_b, gate_a}, 8'd0);
    chk("R1 sda_oe during reset", {7'd0, sda_oe}, 8'd0);
    rst = 1'b0;
    wc(20);

    // Table walk: R2, R3, R4, R6
    for (int i = 0; i < 8; i++) begin
      logic [22:0] v;
      v = VEC[i];
      strap_hi = v[22:21];
      strap_lo = v[20:19];
      wc(10);
      bus_start();
      bus_byte(v[18:11], ack);
      chk(v[11] ? "R6 read address ack" : "R4 address ack", {7'd0, ack}, {7'd0, v[2]});
      if (ack) begin
        bus_byte(v[10:3], ack);
        chk("R5 command ack", {7'd0, ack}, 8'd1);
        chk("R3 gates before stop", {6'd0, gate_b, gate_a}, {6'd0, exp_g});
      end
      bus_stop();
      wc(50);
      exp_g = v[1:0];
      chk("R2 gates after stop", {6'd0, gate_b, gate_a}, {6'd0, exp_g});
    end

    // R7: repeated start discards the pending command (address 0x4F)
    bus_start();
    bus_byte(8'h9E, ack);
    bus_byte(8'h01, ack);
    bus_rstart();
    bus_stop();
    wc(50);
    chk("R7 repeated start discards", {6'd0, gate_b, gate_a}, 8'h02);

    // R8: stop with no command byte
    bus_start();
    bus_byte(8'h9E, ack);
    chk("R8 address ack", {7'd0, ack}, 8'd1);
    bus_stop();
    wc(50);
    chk("R8 stop without command", {6'd0, gate_b, gate_a}, 8'h02);

    // R9: extra byte not acknowledged, first command applied
    bus_start();
    bus_byte(8'h9E, ack);
    bus_byte(8'h01, ack);
    bus_byte(8'h02, ack);
    chk("R9 extra byte nack", {7'd0, ack}, 8'd0);
    bus_stop();
    wc(50);
    chk("R9 first command applied", {6'd0, gate_b, gate_a}, 8'h01);

    // R10: 2-clock high pulse on data while clock high is no Stop
    bus_start();
    bus_byte(8'h9E, ack);
    bus_byte(8'h02, ack);
    sda_m = 1'b0; wc(Q);
    scl_m = 1'b1; wc(Q);
    sda_m = 1'b1; wc(2);
    sda_m = 1'b0; wc(Q);
    scl_m = 1'b0; wc(Q);
    chk("R10 glitch not a stop", {6'd0, gate_b, gate_a}, 8'h01);
    bus_rstart();
    bus_stop();
    wc(50);
    chk("R10 pending dropped after glitch", {6'd0, gate_b, gate_a}, 8'h01);

    // R1: reset in mid-operation
    rst = 1'b1; wc(3);
    chk("R1 gates cleared by reset", {6'd0, gate_b, gate_a}, 8'd0);
    chk("R1 sda_oe cleared by reset", {7'd0, sda_oe}, 8'd0);
    rst = 1'b0; wc(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule